// File: doc/BRIEF.md
# Hardware Breakpoint Match Unit

This block watches every memory access that a processor core issues and compares it against up to four programmed breakpoint addresses. Each slot is configured with a pair of enables, a condition code that selects which kinds of access it watches (instruction fetch, data write, or data read-or-write), and a length code that widens a data watchpoint to an aligned window of 1, 2, 4 or 8 bytes. When an armed slot matches, the block records that slot in a sticky status word and raises a one-cycle trap request toward the exception logic.

Software programs the slots through a small indexed register port: four address registers, one control register and one status register. A task-switch pulse from the core drops every per-task (local) enable while leaving the machine-wide (global) enables alone. Addresses are treated as already translated; the block performs no translation and has no notion of I/O space.

Top module: `bkpt_match_unit`

## Requirements
- R1: The register port has six entries selected by `reg_addr`: 0 to 3 are the slot address registers, 4 is the control register, 5 is the status register (slot hits in bits 0 to 3, upper bits read zero); a write lands on the clock edge where `reg_we` is high, reads are combinational, and every register resets to zero.
- R2: In the control register, bit 2i is the local enable and bit 2i+1 the global enable of slot i; a slot is armed when either is set, and an unarmed slot never matches.
- R3: Slot i takes its condition code from control bits 16+4i and 17+4i and its length code from bits 18+4i and 19+4i.
- R4: Condition 00 matches only fetches (`acc_kind` 00) whose address equals the slot address exactly; the length code and the access size play no part.
- R5: Condition 01 matches only data writes (`acc_kind` 01); the slot covers an aligned window whose length code is 00 = 1 byte, 01 = 2 bytes, 11 = 4 bytes, 10 = 8 bytes, with the slot address rounded down to that length.
- R6: Condition 11 matches data reads (`acc_kind` 10) and data writes over the same aligned window, and never fetches.
- R7: Condition 10 never produces a match, whatever the access.
- R8: `acc_size` gives the access width as 2^n bytes (0 = 1, 1 = 2, 2 = 4, 3 = 8); a data match occurs when any byte of the access falls inside the slot window.
- R9: Status bits are sticky: every slot that matches on an access sets its bit in the same cycle, and bits are cleared only by a write to the status register.
- R10: `trap_req` is high for exactly the one cycle after a cycle with at least one match, and the matching status bits are visible in that same cycle.
- R11: A `task_switch` pulse clears all local enables and leaves global enables and the field bits unchanged, also when it coincides with a control write (the write is applied first).
- R12: When a status write and a match happen in the same cycle, the new status is the written value with the matching bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 32 | Access byte address |
| acc_size | input | 2 | Access width, 2^n bytes |
| acc_kind | input | 2 | 00 fetch, 01 write, 10 read, 11 none |
| task_switch | input | 1 | One-cycle task switch pulse |
| trap_req | output | 1 | One-cycle debug trap request |
| hit_status | output | 4 | Sticky per-slot hit bits |

## Verification
A wrong enable, condition or length bit inside a slot shows up one cycle after the offending access, as a missing or spurious `trap_req` together with a wrong bit in `hit_status`. A corrupted status register is visible on `hit_status` immediately and stays visible because the bits are sticky, so any later check of the status word exposes it. A task switch that clears the wrong enables is seen at once when the control register is read back, and again on the next access aimed at the affected slot.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'b00,
    KIND_WRITE = 2'b01,
    KIND_READ  = 2'b10,
    KIND_NONE  = 2'b11
  } acc_kind_e;

  localparam logic [1:0] COND_EXEC = 2'b00;
  localparam logic [1:0] COND_WR   = 2'b01;
  localparam logic [1:0] COND_IO   = 2'b10;
  localparam logic [1:0] COND_RW   = 2'b11;

  // bit position where the per-slot condition/length nibbles start
  localparam int FIELD_BASE = 16;

  // window length in bytes for a slot length code
  function automatic logic [3:0] win_bytes(input logic [1:0] code);
    case (code)
      2'b00:   return 4'd1;
      2'b01:   return 4'd2;
      2'b11:   return 4'd4;
      default: return 4'd8;
    endcase
  endfunction

  // access width in bytes for an access size code
  function automatic logic [3:0] acc_bytes(input logic [1:0] sz);
    return 4'd1 << sz;
  endfunction

  // true when the access bytes and the aligned slot window share a byte
  function automatic logic spans_overlap(input logic [63:0] slot_addr,
                                         input logic [1:0]  len_code,
                                         input logic [63:0] a_addr,
                                         input logic [1:0]  sz);
    logic [64:0] wlen, alen, wlo, whi, alo, ahi;
    wlen = 65'(win_bytes(len_code));
    alen = 65'(acc_bytes(sz));
    wlo  = {1'b0, slot_addr} & ~(wlen - 65'd1);
    whi  = wlo + wlen - 65'd1;
    alo  = {1'b0, a_addr};
    ahi  = alo + alen - 65'd1;
    return (alo <= whi) && (wlo <= ahi);
  endfunction

endpackage

// File: rtl/bkpt_regs.sv
module bkpt_regs
  import bkpt_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 3,
  parameter int CTL_W     = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_we,
  input  logic [IDX_W-1:0]            reg_addr,
  input  logic [DATA_W-1:0]           reg_wdata,
  input  logic                        task_switch,
  output logic [NUM_SLOTS*ADDR_W-1:0] slot_addr_flat,
  output logic [CTL_W-1:0]            ctl_q
);

  localparam logic [IDX_W-1:0] CTL_IDX = IDX_W'(NUM_SLOTS);

  logic             ctl_wr;
  logic [CTL_W-1:0] ctl_next;
  logic [NUM_SLOTS-1:0] local_en, global_en;

  assign ctl_wr = reg_we && (reg_addr == CTL_IDX);

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_addr
    logic [ADDR_W-1:0] addr_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        addr_q <= '0;
      else if (reg_we && reg_addr == IDX_W'(i))
        addr_q <= reg_wdata[ADDR_W-1:0];
    end
    assign slot_addr_flat[i*ADDR_W +: ADDR_W] = addr_q;
    assign local_en[i]  = ctl_q[2*i];
    assign global_en[i] = ctl_q[2*i+1];
  end

  // control write first, then the task switch strips local enables
  always_comb begin
    ctl_next = ctl_q;
    if (ctl_wr)
      ctl_next = reg_wdata[CTL_W-1:0];
    if (task_switch)
      for (int i = 0; i < NUM_SLOTS; i++)
        ctl_next[2*i] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_next;
  end

  assert_ts_clears_local_R11: assert property (@(posedge clk) disable iff (!rst_n)
    task_switch |=> (local_en == '0));

  assert_ts_keeps_global_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (task_switch && !ctl_wr) |=> (global_en == $past(global_en)));

  assert_ctl_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_we && !task_switch) |=> $stable(ctl_q));

endmodule

// File: rtl/bkpt_slot.sv
module bkpt_slot
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  input  logic [1:0]        acc_kind,
  input  logic [ADDR_W-1:0] slot_addr,
  input  logic              local_en,
  input  logic              global_en,
  input  logic [1:0]        cond,
  input  logic [1:0]        len_code,
  output logic              hit
);

  logic armed, exact_ok, range_ok, kind_ok, where_ok;

  assign armed    = local_en | global_en;
  assign exact_ok = (acc_addr == slot_addr);
  assign range_ok = spans_overlap(64'(slot_addr), len_code, 64'(acc_addr), acc_size);

  always_comb begin
    kind_ok  = 1'b0;
    where_ok = 1'b0;
    case (cond)
      COND_EXEC: begin
        kind_ok  = (acc_kind == KIND_FETCH);
        where_ok = exact_ok;
      end
      COND_WR: begin
        kind_ok  = (acc_kind == KIND_WRITE);
        where_ok = range_ok;
      end
      COND_RW: begin
        kind_ok  = (acc_kind == KIND_WRITE) || (acc_kind == KIND_READ);
        where_ok = range_ok;
      end
      default: begin
        kind_ok  = 1'b0;
        where_ok = 1'b0;
      end
    endcase
  end

  assign hit = acc_valid & armed & kind_ok & where_ok;

  assert_unarmed_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !hit);

  assert_io_cond_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cond == COND_IO) |-> !hit);

  assert_exec_exact_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cond == COND_EXEC) |-> (acc_addr == slot_addr && acc_kind == KIND_FETCH));

  assert_rw_no_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cond != COND_EXEC) |-> (acc_kind != KIND_FETCH));

endmodule

// File: rtl/bkpt_status.sv
module bkpt_status #(
  parameter int NUM_SLOTS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sts_wr,
  input  logic [NUM_SLOTS-1:0] sts_wdata,
  input  logic [NUM_SLOTS-1:0] hits,
  output logic [NUM_SLOTS-1:0] status_q,
  output logic                 trap_q
);

  logic [NUM_SLOTS-1:0] status_base;

  // written value takes effect first, then this cycle's hits are merged
  assign status_base = sts_wr ? sts_wdata : status_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      trap_q   <= 1'b0;
    end else begin
      status_q <= status_base | hits;
      trap_q   <= |hits;
    end
  end

  assert_status_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sts_wr |=> ((status_q & $past(status_q)) == $past(status_q)));

  assert_hits_recorded_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hits != '0) |=> ((status_q & $past(hits)) == $past(hits)));

  assert_trap_has_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trap_q |-> (status_q != '0));

  assert_write_then_hit_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && hits == '0) |=> (status_q == $past(sts_wdata)));

endmodule

// File: rtl/bkpt_match_unit.sv
module bkpt_match_unit
  import bkpt_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [2:0]           reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  input  logic                 acc_valid,
  input  logic [ADDR_W-1:0]    acc_addr,
  input  logic [1:0]           acc_size,
  input  logic [1:0]           acc_kind,
  input  logic                 task_switch,
  output logic                 trap_req,
  output logic [NUM_SLOTS-1:0] hit_status
);

  localparam int IDX_W = 3;
  localparam int CTL_W = FIELD_BASE + 4 * NUM_SLOTS;
  localparam logic [IDX_W-1:0] CTL_IDX = IDX_W'(NUM_SLOTS);
  localparam logic [IDX_W-1:0] STS_IDX = IDX_W'(NUM_SLOTS + 1);

  logic [NUM_SLOTS*ADDR_W-1:0] slot_addr_flat;
  logic [CTL_W-1:0]            ctl_q;
  logic [NUM_SLOTS-1:0]        hits;
  logic [NUM_SLOTS-1:0]        status_q;
  logic                        trap_q;
  logic                        sts_wr;

  bkpt_regs #(
    .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .IDX_W(IDX_W), .CTL_W(CTL_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .task_switch(task_switch),
    .slot_addr_flat(slot_addr_flat), .ctl_q(ctl_q)
  );

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    bkpt_slot #(.ADDR_W(ADDR_W)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(acc_valid), .acc_addr(acc_addr),
      .acc_size(acc_size), .acc_kind(acc_kind),
      .slot_addr(slot_addr_flat[i*ADDR_W +: ADDR_W]),
      .local_en(ctl_q[2*i]), .global_en(ctl_q[2*i+1]),
      .cond(ctl_q[FIELD_BASE + 4*i +: 2]),
      .len_code(ctl_q[FIELD_BASE + 4*i + 2 +: 2]),
      .hit(hits[i])
    );
  end

  assign sts_wr = reg_we && (reg_addr == STS_IDX);

  bkpt_status #(.NUM_SLOTS(NUM_SLOTS)) u_status (
    .clk(clk), .rst_n(rst_n), .sts_wr(sts_wr),
    .sts_wdata(reg_wdata[NUM_SLOTS-1:0]), .hits(hits),
    .status_q(status_q), .trap_q(trap_q)
  );

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_SLOTS; i++)
      if (reg_addr == IDX_W'(i))
        reg_rdata = DATA_W'(slot_addr_flat[i*ADDR_W +: ADDR_W]);
    if (reg_addr == CTL_IDX) reg_rdata = DATA_W'(ctl_q);
    if (reg_addr == STS_IDX) reg_rdata = DATA_W'(status_q);
  end

  assign trap_req   = trap_q;
  assign hit_status = status_q;

  assert_trap_follows_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && hits == '0) |=> !trap_req);

endmodule

// File: tb/bkpt_match_unit_bench.sv
module bkpt_match_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [1:0]  acc_size = '0;
  logic [1:0]  acc_kind = 2'b11;
  logic        task_switch = 1'b0;
  logic        trap_req;
  logic [3:0]  hit_status;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;
  logic [3:0] exp_sts = '0;

  always #5 clk = ~clk;

  bkpt_match_unit u_bkpt_match_unit (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_kind(acc_kind),
    .task_switch(task_switch), .trap_req(trap_req), .hit_status(hit_status)
  );

  localparam logic [1:0] FETCH = 2'b00, WR = 2'b01, RD = 2'b10;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // slot configuration word built from the field layout of R2 and R3
  function automatic logic [31:0] cfg(int s, bit l, bit g, logic [1:0] c, logic [1:0] n);
    logic [31:0] v;
    v = '0;
    v[2*s]             = l;
    v[2*s+1]           = g;
    v[16+4*s +: 2]     = c;
    v[18+4*s +: 2]     = n;
    return v;
  endfunction

  task automatic wr_reg(int idx, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'(idx); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_check(string req, int idx, logic [31:0] exp);
    @(negedge clk);
    reg_addr = 3'(idx);
    #1 check(req, reg_rdata, exp);
  endtask

  task automatic clear_sts();
    wr_reg(5, 32'h0);
    exp_sts = '0;
  endtask

  // one access, then a quiet cycle; mask is the set of slots expected to hit
  task automatic access(string req, logic [31:0] a, logic [1:0] sz, logic [1:0] k, logic [3:0] mask);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_size = sz; acc_kind = k;
    @(posedge clk);
    #1;
    exp_sts = exp_sts | mask;
    check({req, " trap"}, 32'(trap_req), 32'(mask != 4'd0));
    check({req, " status"}, 32'(hit_status), 32'(exp_sts));
    @(negedge clk);
    acc_valid = 1'b0; acc_kind = 2'b11;
    @(posedge clk);
    #1 check("R10 trap one cycle", 32'(trap_req), 32'h0);
    check("R9 status held", 32'(hit_status), 32'(exp_sts));
  endtask

  task automatic t_reset();
    for (int i = 0; i < 6; i++) rd_check("R1 reset value", i, 32'h0);
    check("R10 reset trap", 32'(trap_req), 32'h0);
  endtask

  task automatic t_regs();
    for (int i = 0; i < 4; i++) wr_reg(i, 32'hA000_0000 + 32'(i * 16 + 3));
    for (int i = 0; i < 4; i++) rd_check("R1 address readback", i, 32'hA000_0000 + 32'(i * 16 + 3));
    wr_reg(4, 32'h5A5A_00FF);
    rd_check("R1 control readback", 4, 32'h5A5A_00FF);
    wr_reg(4, 32'h0);
  endtask

  task automatic t_exec();
    wr_reg(0, 32'h1000);
    wr_reg(4, cfg(0, 1, 0, 2'b00, 2'b11));
    clear_sts();
    access("R4 fetch exact", 32'h1000, 2'd1, FETCH, 4'b0001);
    clear_sts();
    access("R4 fetch off by one", 32'h1001, 2'd0, FETCH, 4'b0000);
    access("R4 write not fetch", 32'h1000, 2'd0, WR, 4'b0000);
  endtask

  task automatic t_write();
    wr_reg(1, 32'h2002);
    wr_reg(4, cfg(1, 0, 1, 2'b01, 2'b11));
    clear_sts();
    access("R5 R3 write in window", 32'h2003, 2'd0, WR, 4'b0010);
    clear_sts();
    access("R5 write past window", 32'h2004, 2'd0, WR, 4'b0000);
    access("R5 read ignored", 32'h2000, 2'd0, RD, 4'b0000);
    access("R8 4B write straddles", 32'h1FFE, 2'd2, WR, 4'b0010);
    clear_sts();
    access("R8 8B write below", 32'h1FF8, 2'd3, WR, 4'b0000);
  endtask

  task automatic t_rw();
    wr_reg(2, 32'h3005);
    wr_reg(3, 32'h4001);
    wr_reg(4, cfg(2, 1, 0, 2'b11, 2'b10) | cfg(3, 0, 1, 2'b11, 2'b01));
    clear_sts();
    access("R6 8B read hit", 32'h3007, 2'd0, RD, 4'b0100);
    access("R6 write hit", 32'h3000, 2'd1, WR, 4'b0100);
    clear_sts();
    access("R6 read past window", 32'h3008, 2'd0, RD, 4'b0000);
    access("R6 fetch ignored", 32'h3000, 2'd0, FETCH, 4'b0000);
    access("R5 2B window miss", 32'h4002, 2'd0, RD, 4'b0000);
    access("R5 2B window hit", 32'h4000, 2'd0, RD, 4'b1000);
  endtask

  task automatic t_reserved();
    wr_reg(0, 32'h5000);
    wr_reg(4, cfg(0, 1, 1, 2'b10, 2'b11));
    clear_sts();
    access("R7 io read", 32'h5000, 2'd0, RD, 4'b0000);
    access("R7 io write", 32'h5000, 2'd2, WR, 4'b0000);
    access("R7 io fetch", 32'h5000, 2'd0, FETCH, 4'b0000);
  endtask

  task automatic t_disabled();
    wr_reg(3, 32'h6000);
    wr_reg(4, cfg(3, 0, 0, 2'b11, 2'b00));
    clear_sts();
    access("R2 unarmed slot", 32'h6000, 2'd0, RD, 4'b0000);
    wr_reg(4, cfg(3, 0, 1, 2'b11, 2'b00));
    access("R2 global only armed", 32'h6000, 2'd0, RD, 4'b1000);
  endtask

  task automatic t_multi();
    wr_reg(0, 32'h7000);
    wr_reg(1, 32'h7002);
    wr_reg(4, cfg(0, 1, 0, 2'b11, 2'b11) | cfg(1, 0, 1, 2'b11, 2'b11));
    clear_sts();
    access("R9 two slots one access", 32'h7000, 2'd2, RD, 4'b0011);
    access("R9 sticky after miss", 32'h9000, 2'd0, RD, 4'b0000);
    wr_reg(5, 32'h4);
    exp_sts = 4'b0100;
    rd_check("R9 status write", 5, 32'h4);
    clear_sts();
    rd_check("R9 status cleared", 5, 32'h0);
  endtask

  task automatic t_task_switch();
    logic [31:0] c;
    wr_reg(0, 32'h8000);
    wr_reg(1, 32'h8100);
    wr_reg(2, 32'h8200);
    c = cfg(0, 1, 0, 2'b11, 2'b00) | cfg(1, 0, 1, 2'b11, 2'b00) | cfg(2, 1, 1, 2'b11, 2'b00);
    wr_reg(4, c);
    @(negedge clk); task_switch = 1'b1;
    @(negedge clk); task_switch = 1'b0;
    rd_check("R11 locals cleared", 4, c & ~32'h55);
    clear_sts();
    access("R11 local slot dropped", 32'h8000, 2'd0, RD, 4'b0000);
    access("R11 global slot kept", 32'h8100, 2'd0, RD, 4'b0010);
    access("R11 both-enable slot kept", 32'h8200, 2'd0, RD, 4'b0100);
    // control write coinciding with the pulse
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = c; task_switch = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; task_switch = 1'b0;
    rd_check("R11 write then clear", 4, c & ~32'h55);
  endtask

  task automatic t_same_cycle();
    // status holds 0110 here; write 0 while slot 1 hits
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd5; reg_wdata = 32'h0;
    acc_valid = 1'b1; acc_addr = 32'h8100; acc_size = 2'd0; acc_kind = RD;
    @(posedge clk);
    #1;
    check("R12 write then hit status", 32'(hit_status), 32'h2);
    check("R12 trap", 32'(trap_req), 32'h1);
    @(negedge clk);
    reg_we = 1'b0; acc_valid = 1'b0; acc_kind = 2'b11;
    exp_sts = 4'b0010;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_exec();
    t_write();
    t_rw();
    t_reserved();
    t_disabled();
    t_multi();
    t_task_switch();
    t_same_cycle();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule